// File: doc/BRIEF.md
# Instruction-Energy Power Estimator

This block gives a live estimate of a processor core's power draw without any analogue sensing. The core pipeline presents one beat per retired instruction, carrying a small class code. For each accepted beat the block reads that class's characterised energy cost from a writable table and adds it to a per-window energy sum. A monitoring window is a fixed power-of-two count of clock cycles. When a window closes, the sum is divided by the window length with a right shift and the quotient is latched as the average power of that window. The raw window energy is latched with it, and a one-cycle flag marks the new result for a downstream thermal model or a status reader. A lifetime energy total runs alongside and never clears while the monitor runs.

The table is loaded through a plain address/data/write-enable port while monitoring is switched off. Writes made while the monitor is on are dropped. The instruction input is a valid/ready stream. Ready follows the monitor enable, so the block never pushes back on the core while it is monitoring, and beats offered while it is disabled are neither taken nor counted. The power result has no ready. A consumer must capture it in the cycle its flag is high.

Top module: `insn_power_est`

## Requirements
- R1: While rst_n is low, every output is zero and every table entry reads back as zero.
- R2: With mon_en low, a cycle with cfg_we high writes cfg_wdata into entry cfg_addr. From the next cycle on, cfg_rdata shows that value whenever cfg_addr selects the entry.
- R3: With mon_en high, cfg_we has no effect, and the entry keeps its previous value as seen on cfg_rdata.
- R4: inst_ready equals mon_en. A beat (inst_valid and inst_ready both high) adds the table entry selected by inst_cls to the window sum. Beats offered with mon_en low change no energy figure.
- R5: A window is 2^WIN_LOG2 consecutive enabled cycles, counted from the first enabled cycle. In the cycle after a window's last cycle:
  - pwr_valid is high for exactly one cycle.
  - win_energy holds that window's sum.
  - pwr_out holds that sum shifted right by WIN_LOG2.
- R6: The window sum saturates at 2^ACC_W-1 instead of wrapping.
- R7: A beat accepted in the last cycle of a window counts toward the following window, not the closing one.
- R8: life_energy adds the energy of every accepted beat across all windows. It is not cleared by window ends or by disabling.
- R9: Driving mon_en low restarts the window count and discards the partial window sum. pwr_out and win_energy keep their last latched values, and pwr_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitor enable; also gates table writes |
| inst_valid | input | 1 | Retired-instruction beat offered |
| inst_ready | output | 1 | Beat accepted (equals mon_en) |
| inst_cls | input | CLASS_W | Instruction class of the beat |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | CLASS_W | Table entry for write and read-back |
| cfg_wdata | input | ENERGY_W | Energy value to write |
| cfg_rdata | output | ENERGY_W | Current content of entry cfg_addr |
| pwr_valid | output | 1 | One-cycle flag: new result latched |
| pwr_out | output | ACC_W-WIN_LOG2 | Average power of the last closed window |
| win_energy | output | ACC_W | Energy sum of the last closed window |
| life_energy | output | LIFE_W | Running energy total |

## Verification
The following beat patterns are used, each isolating one behaviour:
- A window with a single beat placed in its last cycle shows whether boundary beats land in the next window.
- Back-to-back beats of the costliest class overflow the window sum and expose wrapping instead of saturation.
- Dropping the enable mid-window, with beats still offered, shows both the discarded partial sum and the ignored beats.
- A write attempted while enabled, then read back, shows whether writes are gated.
- A long random mix of classes, beat density and enable toggling is compared cycle by cycle against a behavioural model. It catches errors in the shift amount, window length and lifetime total.

// File: rtl/ipe_pkg.sv
package ipe_pkg;
  localparam int unsigned DEF_CLASS_W  = 4;
  localparam int unsigned DEF_ENERGY_W = 12;
  localparam int unsigned DEF_ACC_W    = 16;
  localparam int unsigned DEF_LIFE_W   = 32;
  localparam int unsigned DEF_WIN_LOG2 = 6;
endpackage

// File: rtl/ipe_energy_table.sv
module ipe_energy_table #(
  parameter int unsigned CLASS_W  = 4,
  parameter int unsigned ENERGY_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CLASS_W-1:0]  wr_addr,
  input  logic [ENERGY_W-1:0] wr_data,
  input  logic [CLASS_W-1:0]  lk_addr,
  output logic [ENERGY_W-1:0] lk_data,
  input  logic [CLASS_W-1:0]  rb_addr,
  output logic [ENERGY_W-1:0] rb_data
);
  localparam int unsigned ENTRIES = 1 << CLASS_W;

  logic [ENERGY_W-1:0] cost [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cost[g] <= '0;
      else if (wr_en && (wr_addr == CLASS_W'(g)))
        cost[g] <= wr_data;
    end
  end

  assign lk_data = cost[lk_addr];
  assign rb_data = cost[rb_addr];
endmodule

// File: rtl/ipe_window_timer.sv
module ipe_window_timer #(
  parameter int unsigned WIN_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  logic [WIN_LOG2-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick <= '0;
    else if (!run)
      tick <= '0;
    else
      tick <= tick + 1'b1;
  end

  assign last = run && (&tick);
endmodule

// File: rtl/ipe_accum.sv
module ipe_accum #(
  parameter int unsigned ENERGY_W = 12,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned LIFE_W   = 32,
  parameter int unsigned WIN_LOG2 = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      last,
  input  logic                      add_en,
  input  logic [ENERGY_W-1:0]       add_val,
  output logic                      pwr_valid,
  output logic [ACC_W-WIN_LOG2-1:0] pwr_out,
  output logic [ACC_W-1:0]          win_energy,
  output logic [LIFE_W-1:0]         life_energy
);
  localparam int unsigned PWR_W = ACC_W - WIN_LOG2;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W:0]    acc_sum;
  logic [ACC_W-1:0]  acc_next;
  logic [ACC_W-1:0]  add_acc;
  logic [LIFE_W:0]   life_sum;
  logic [LIFE_W-1:0] life_next;

  always_comb begin
    add_acc  = add_en ? ACC_W'(add_val) : '0;
    acc_sum  = {1'b0, acc} + {1'b0, add_acc};
    acc_next = acc_sum[ACC_W] ? {ACC_W{1'b1}} : acc_sum[ACC_W-1:0];
    life_sum = {1'b0, life_energy} + (LIFE_W+1)'(add_acc);
    life_next = life_sum[LIFE_W] ? {LIFE_W{1'b1}} : life_sum[LIFE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc         <= '0;
      pwr_valid   <= 1'b0;
      pwr_out     <= '0;
      win_energy  <= '0;
      life_energy <= '0;
    end else begin
      pwr_valid   <= 1'b0;
      life_energy <= life_next;
      if (!run) begin
        acc <= '0;
      end else if (last) begin
        pwr_out    <= acc[ACC_W-1 -: PWR_W];
        win_energy <= acc;
        pwr_valid  <= 1'b1;
        acc        <= add_acc;
      end else begin
        acc <= acc_next;
      end
    end
  end
endmodule

// File: rtl/insn_power_est.sv
module insn_power_est
  import ipe_pkg::*;
#(
  parameter int unsigned CLASS_W  = DEF_CLASS_W,
  parameter int unsigned ENERGY_W = DEF_ENERGY_W,
  parameter int unsigned ACC_W    = DEF_ACC_W,
  parameter int unsigned LIFE_W   = DEF_LIFE_W,
  parameter int unsigned WIN_LOG2 = DEF_WIN_LOG2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mon_en,
  input  logic                      inst_valid,
  output logic                      inst_ready,
  input  logic [CLASS_W-1:0]        inst_cls,
  input  logic                      cfg_we,
  input  logic [CLASS_W-1:0]        cfg_addr,
  input  logic [ENERGY_W-1:0]       cfg_wdata,
  output logic [ENERGY_W-1:0]       cfg_rdata,
  output logic                      pwr_valid,
  output logic [ACC_W-WIN_LOG2-1:0] pwr_out,
  output logic [ACC_W-1:0]          win_energy,
  output logic [LIFE_W-1:0]         life_energy
);
  logic                beat;
  logic                tbl_wr;
  logic                win_last;
  logic [ENERGY_W-1:0] beat_cost;

  assign inst_ready = mon_en;
  assign beat       = inst_valid && mon_en;
  assign tbl_wr     = cfg_we && !mon_en;

  ipe_energy_table #(.CLASS_W(CLASS_W), .ENERGY_W(ENERGY_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .lk_addr(inst_cls), .lk_data(beat_cost),
    .rb_addr(cfg_addr), .rb_data(cfg_rdata)
  );

  ipe_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(mon_en), .last(win_last)
  );

  ipe_accum #(.ENERGY_W(ENERGY_W), .ACC_W(ACC_W), .LIFE_W(LIFE_W),
              .WIN_LOG2(WIN_LOG2)) u_accum (
    .clk(clk), .rst_n(rst_n), .run(mon_en), .last(win_last),
    .add_en(beat), .add_val(beat_cost),
    .pwr_valid(pwr_valid), .pwr_out(pwr_out),
    .win_energy(win_energy), .life_energy(life_energy)
  );
endmodule

// File: rtl/ipe_checker.sv
module ipe_checker #(
  parameter int unsigned CLASS_W  = 4,
  parameter int unsigned ENERGY_W = 12,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned LIFE_W   = 32,
  parameter int unsigned WIN_LOG2 = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mon_en,
  input logic                      cfg_we,
  input logic [CLASS_W-1:0]        cfg_addr,
  input logic [ENERGY_W-1:0]       cfg_wdata,
  input logic [ENERGY_W-1:0]       cfg_rdata,
  input logic                      pwr_valid,
  input logic [ACC_W-WIN_LOG2-1:0] pwr_out,
  input logic [ACC_W-1:0]          win_energy,
  input logic [LIFE_W-1:0]         life_energy
);
  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |=> !pwr_valid);

  // R5
  pwr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |-> (pwr_out == win_energy[ACC_W-1:WIN_LOG2]));

  // R9
  off_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !pwr_valid);

  // R8
  life_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (life_energy >= $past(life_energy)));

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !mon_en) |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata)));

  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && mon_en) |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_rdata)));
endmodule

bind insn_power_est ipe_checker #(
  .CLASS_W(CLASS_W), .ENERGY_W(ENERGY_W), .ACC_W(ACC_W),
  .LIFE_W(LIFE_W), .WIN_LOG2(WIN_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .pwr_valid(pwr_valid), .pwr_out(pwr_out), .win_energy(win_energy),
  .life_energy(life_energy)
);

// File: tb/sim_insn_power_est.sv
module sim_insn_power_est;
  localparam int CW = 4, EW = 12, AW = 16, LW = 32, WL = 6;
  localparam int WIN = 1 << WL;
  localparam longint ACC_MAX  = (64'd1 << AW) - 1;
  localparam longint LIFE_MAX = (64'd1 << LW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, mon_en = 1'b0, inst_valid = 1'b0, cfg_we = 1'b0;
  logic [CW-1:0] inst_cls = '0, cfg_addr = '0;
  logic [EW-1:0] cfg_wdata = '0;
  logic inst_ready, pwr_valid;
  logic [EW-1:0] cfg_rdata;
  logic [AW-WL-1:0] pwr_out;
  logic [AW-1:0] win_energy;
  logic [LW-1:0] life_energy;

  insn_power_est u0 (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .inst_valid(inst_valid),
    .inst_ready(inst_ready), .inst_cls(inst_cls), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pwr_valid(pwr_valid), .pwr_out(pwr_out), .win_energy(win_energy),
    .life_energy(life_energy)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_tbl[16];
  int m_cnt = 0;
  longint m_acc = 0, m_pwr = 0, m_wen = 0, m_life = 0;
  bit m_pv = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    longint e;
    if (!rst_n) begin
      foreach (m_tbl[i]) m_tbl[i] = 0;
      m_cnt = 0; m_acc = 0; m_pwr = 0; m_wen = 0; m_life = 0; m_pv = 0;
      return;
    end
    e = (inst_valid && mon_en) ? m_tbl[inst_cls] : 0;
    if (cfg_we && !mon_en) m_tbl[cfg_addr] = cfg_wdata;
    m_life = (m_life + e > LIFE_MAX) ? LIFE_MAX : m_life + e;
    m_pv = 0;
    if (!mon_en) begin
      m_cnt = 0; m_acc = 0;
    end else if (m_cnt == WIN - 1) begin
      m_pwr = m_acc / WIN; m_wen = m_acc; m_pv = 1;
      m_acc = e; m_cnt = 0;
    end else begin
      m_acc = (m_acc + e > ACC_MAX) ? ACC_MAX : m_acc + e;
      m_cnt++;
    end
  endtask

  task automatic compare_all();
    chk("R5", "pwr_valid", pwr_valid, m_pv);
    chk("R5", "pwr_out", pwr_out, m_pwr);
    chk("R5", "win_energy", win_energy, m_wen);
    chk("R8", "life_energy", life_energy, m_life);
    chk("R4", "inst_ready", inst_ready, mon_en);
    chk("R2", "cfg_rdata", cfg_rdata, m_tbl[cfg_addr]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_drive();
    inst_valid = 0; cfg_we = 0;
  endtask

  initial begin
    int saved;
    longint life_before;
    // R1 reset state
    repeat (3) cyc();
    chk("R1", "reset pwr_valid", pwr_valid, 0);
    chk("R1", "reset life_energy", life_energy, 0);
    cfg_addr = 5;
    #1 chk("R1", "reset table entry", cfg_rdata, 0);
    @(negedge clk);
    rst_n = 1;

    // R2 program table while disabled
    for (int a = 0; a < 16; a++) begin
      cfg_we = 1; cfg_addr = CW'(a);
      cfg_wdata = (a == 15) ? EW'(4095) : EW'(a * 37 + 5);
      cyc();
    end
    cfg_we = 0; cfg_addr = 7; cyc();
    chk("R2", "entry 7 written", cfg_rdata, 7 * 37 + 5);

    // R3 write attempt while enabled
    mon_en = 1; cfg_we = 1; cfg_addr = 3; cfg_wdata = 999; cyc();
    cfg_we = 0; mon_en = 0; cyc();
    chk("R3", "entry 3 kept", cfg_rdata, 3 * 37 + 5);

    // R7 beat only in last cycle of window
    mon_en = 1; inst_cls = 2;
    for (int k = 0; k < WIN; k++) begin inst_valid = (k == WIN - 1); cyc(); end
    chk("R7", "boundary window valid", pwr_valid, 1);
    chk("R7", "boundary beat excluded", win_energy, 0);
    inst_valid = 0;
    for (int k = 0; k < WIN; k++) cyc();
    chk("R7", "boundary beat in next window", win_energy, 2 * 37 + 5);

    // R4/R5 dense mixed window
    for (int k = 0; k < WIN; k++) begin
      inst_valid = (k % 3 != 1); inst_cls = CW'(k % 8); cyc();
    end
    chk("R5", "dense window flag", pwr_valid, 1);

    // R6 saturation
    inst_cls = 15; inst_valid = 1;
    for (int k = 0; k < WIN; k++) cyc();
    chk("R6", "saturated sum", win_energy, ACC_MAX);
    chk("R6", "saturated power", pwr_out, ACC_MAX >> WL);

    // R9 disable mid-window, beats ignored (R4)
    inst_cls = 4; inst_valid = 1;
    for (int k = 0; k < WIN; k++) cyc();
    for (int k = 0; k < 20; k++) cyc();
    saved = win_energy;
    mon_en = 0; life_before = life_energy;
    for (int k = 0; k < 5; k++) cyc();
    chk("R4", "beats ignored when off", life_energy, life_before);
    chk("R9", "result held when off", win_energy, saved);
    inst_valid = 0; mon_en = 1;
    for (int k = 0; k < WIN; k++) cyc();
    chk("R9", "partial sum discarded", win_energy, 0);

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      inst_valid = $urandom_range(0, 1);
      inst_cls   = CW'($urandom_range(0, 15));
      mon_en     = ($urandom_range(0, 99) != 0);
      cfg_we     = ($urandom_range(0, 9) == 0);
      cfg_addr   = CW'($urandom_range(0, 15));
      cfg_wdata  = EW'($urandom_range(0, 4095));
      cyc();
    end
    idle_drive();
    chk("R8", "lifetime nonzero", (life_energy > 0), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule